// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is one shared counting semaphore used by several hardware threads to coordinate. It keeps a 16-bit count and a small tag (T, F and E flags). Requesters reach it through a single request port. The port carries a view code, a read/write flag, a requester number and write data. The view code picks how an access is read. A read in the P/V view acquires a unit, and a write in the P/V view releases one. Each of these has a blocking form and a try form.

A blocking acquire on an empty count does not complete. The cell answers "blocked" and records the requester in a waiter mask. The next release pulses a wake vector carrying every recorded waiter and clears the mask. Suspending and resuming the threads is left to the logic around the cell.

Raw (bypass) and tag (control) views expose the count and the flags. The empty/full queue views have no meaning for a semaphore cell: their reads return zero and their writes are dropped. Every accepted request gets its response on the clock edge after it is presented.

Top module: `sema_cell`

## Requirements
- R1: After reset the count, the T/F/E flags, the waiter mask and all outputs are zero. A tag-view read then returns 0, including the queue-mode flag at bit 17.
- R2: A read in view 4 or 5 with a non-zero count completes with `rsp_done`. It returns the count as it was before the access and lowers the count by one.
- R3: A read in view 4 (blocking) with a zero count answers `rsp_blocked` instead of `rsp_done`, with read data 0. It sets the requester's bit in the waiter mask and leaves the count at zero.
- R4: A read in view 5 (try) with a zero count completes with read data 0 and changes neither the count nor the waiter mask.
- R5: A write in view 4 or 5 ignores its data and raises the count by one. The count saturates at 0xFFFF. The blocking and try forms behave the same.
- R6: A write in view 4 or 5 makes `wake_vec` equal to the waiter mask for exactly one cycle and empties the mask. Nothing else drives `wake_vec` non-zero; in particular, an acquire never wakes a waiter.
- R7: Reads in views 2 and 3 (empty/full) return 0, and writes in those views leave all state unchanged.
- R8: A read in view 0 (raw) returns the count, zero-extended. A write in view 0 is ignored.
- R9: A read in view 1 (tag) returns T at bit 16, F at bit 1 and E at bit 0, with all other bits 0. A write in view 1 loads T, F and E from data bits 16, 1 and 0 and changes nothing else.
- R10: Views 6 to 15 read as all ones, and writes in them are ignored.
- R11: Each request held on `req_valid` gets exactly one of `rsp_done` or `rsp_blocked` on the next cycle. Both are low in cycles without a request. `rsp_rdata` is zero except after a completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 4 | View code (0 raw, 1 tag, 2/3 empty/full, 4 P/V blocking, 5 P/V try) |
| req_id | input | ID_W (3) | Number of the requesting thread |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_done | output | 1 | The previous cycle's request completed |
| rsp_blocked | output | 1 | The previous cycle's request is a blocked acquire |
| rsp_rdata | output | DATA_W (32) | Read data of the completed read |
| wake_vec | output | NUM_REQ (8) | One-cycle pulse of the waiters woken by a release |

## Verification
The bench first runs a directed sequence. It issues blocking and try acquires on an empty cell from different requester numbers. This separates the blocking path, which records a waiter, from the try path, which returns zero and leaves the state untouched. The releases that follow show through `wake_vec` exactly which waiters were recorded, and that a second release wakes nobody.

Acquires on a non-zero count separate the returned pre-decrement value from the new count, which the bench reads back through the raw view. Next comes a long mixed run with every view, idle gaps and random requester numbers. It exercises how the flags, the count and the mask interact.

Finally, more than 65535 releases drive the count into saturation, and further releases must leave it pinned at 0xFFFF.

// File: rtl/sema_pkg.sv
package sema_pkg;

  // View codes seen on req_view
  localparam logic [3:0] VW_RAW    = 4'd0;
  localparam logic [3:0] VW_TAG    = 4'd1;
  localparam logic [3:0] VW_EF_BLK = 4'd2;
  localparam logic [3:0] VW_EF_TRY = 4'd3;
  localparam logic [3:0] VW_PV_BLK = 4'd4;
  localparam logic [3:0] VW_PV_TRY = 4'd5;

  // Bit positions of the tag word
  localparam int TAG_E_BIT    = 0;
  localparam int TAG_F_BIT    = 1;
  localparam int TAG_T_BIT    = 16;
  localparam int TAG_FIFO_BIT = 17;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ACQ_BLK,
    OP_ACQ_TRY,
    OP_REL,
    OP_RAW_RD,
    OP_TAG_RD,
    OP_TAG_WR,
    OP_ZERO_RD,
    OP_ONES_RD,
    OP_DROP_WR
  } op_e;

  typedef struct packed {
    logic t;
    logic f;
    logic e;
  } tag_t;

endpackage

// File: rtl/sema_decode.sv
module sema_decode
  import sema_pkg::*;
(
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [3:0] req_view,
  output op_e        op
);

  always_comb begin
    op = OP_NONE;
    if (req_valid) begin
      case (req_view)
        VW_RAW:    op = req_write ? OP_DROP_WR : OP_RAW_RD;
        VW_TAG:    op = req_write ? OP_TAG_WR  : OP_TAG_RD;
        VW_EF_BLK,
        VW_EF_TRY: op = req_write ? OP_DROP_WR : OP_ZERO_RD;
        VW_PV_BLK: op = req_write ? OP_REL     : OP_ACQ_BLK;
        VW_PV_TRY: op = req_write ? OP_REL     : OP_ACQ_TRY;
        default:   op = req_write ? OP_DROP_WR : OP_ONES_RD;
      endcase
    end
  end

endmodule

// File: rtl/sema_count.sv
module sema_count
  import sema_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero,
  output logic             cnt_max
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_max  = (cnt_q == CNT_TOP);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    case (op)
      OP_ACQ_BLK, OP_ACQ_TRY: begin
        if (!cnt_zero) begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      OP_REL: begin
        if (!cnt_max) begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sema_waitmask.sv
module sema_waitmask
  import sema_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  op_e                op,
  input  logic               cnt_zero,
  input  logic [ID_W-1:0]    req_id,
  output logic [NUM_REQ-1:0] mask_q,
  output logic [NUM_REQ-1:0] wake_q
);

  logic [NUM_REQ-1:0] id_hot;
  logic [NUM_REQ-1:0] mask_d;
  logic [NUM_REQ-1:0] wake_d;
  logic               mask_en;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_hot
    assign id_hot[g] = (req_id == ID_W'(g));
  end

  always_comb begin
    mask_d  = mask_q;
    mask_en = 1'b0;
    if (op == OP_REL) begin
      mask_d  = '0;
      mask_en = 1'b1;
    end else if (op == OP_ACQ_BLK && cnt_zero) begin
      mask_d  = mask_q | id_hot;
      mask_en = 1'b1;
    end
  end

  assign wake_d = (op == OP_REL) ? mask_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= '0;
    else        wake_q <= wake_d;
  end

endmodule

// File: rtl/sema_tag.sv
module sema_tag
  import sema_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  op,
  input  tag_t tag_wr,
  output tag_t tag_q
);

  logic tag_en;

  assign tag_en = (op == OP_TAG_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (tag_en) tag_q <= tag_wr;
  end

endmodule

// File: rtl/sema_cell.sv
module sema_cell
  import sema_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32,
  parameter int ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [3:0]         req_view,
  input  logic [ID_W-1:0]    req_id,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_done,
  output logic               rsp_blocked,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [NUM_REQ-1:0] wake_vec
);

  localparam int PAD_W = DATA_W - CNT_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  op_e                op;
  logic [CNT_W-1:0]   cnt_q;
  logic               cnt_zero;
  logic               cnt_max;
  logic [NUM_REQ-1:0] mask_q;
  tag_t               tag_q;
  tag_t               tag_wr;

  sema_decode u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_view  (req_view),
    .op        (op)
  );

  sema_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_ns),
    .op       (op),
    .cnt_q    (cnt_q),
    .cnt_zero (cnt_zero),
    .cnt_max  (cnt_max)
  );

  sema_waitmask #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_ns),
    .op       (op),
    .cnt_zero (cnt_zero),
    .req_id   (req_id),
    .mask_q   (mask_q),
    .wake_q   (wake_vec)
  );

  assign tag_wr.t = req_wdata[TAG_T_BIT];
  assign tag_wr.f = req_wdata[TAG_F_BIT];
  assign tag_wr.e = req_wdata[TAG_E_BIT];

  sema_tag u_tag (
    .clk    (clk),
    .rst_n  (rst_ns),
    .op     (op),
    .tag_wr (tag_wr),
    .tag_q  (tag_q)
  );

  // response path
  logic              done_d;
  logic              blk_d;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] cnt_ext;
  logic [DATA_W-1:0] tag_word;

  assign cnt_ext = {{PAD_W{1'b0}}, cnt_q};

  always_comb begin
    tag_word               = '0;
    tag_word[TAG_T_BIT]    = tag_q.t;
    tag_word[TAG_F_BIT]    = tag_q.f;
    tag_word[TAG_E_BIT]    = tag_q.e;
    tag_word[TAG_FIFO_BIT] = 1'b0;
  end

  always_comb begin
    blk_d   = (op == OP_ACQ_BLK) && cnt_zero;
    done_d  = (op != OP_NONE) && !blk_d;
    rdata_d = '0;
    case (op)
      OP_ACQ_BLK: rdata_d = cnt_zero ? '0 : cnt_ext;
      OP_ACQ_TRY: rdata_d = cnt_ext;
      OP_RAW_RD:  rdata_d = cnt_ext;
      OP_TAG_RD:  rdata_d = tag_word;
      OP_ONES_RD: rdata_d = '1;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rsp_done    <= 1'b0;
      rsp_blocked <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_done    <= done_d;
      rsp_blocked <= blk_d;
      rsp_rdata   <= rdata_d;
    end
  end

endmodule

// File: rtl/sema_cell_chk.sv
module sema_cell_chk #(
  parameter int NUM_REQ = 8,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 3
) (
  input logic               clk,
  input logic               rst_ns,
  input logic               req_valid,
  input logic               req_write,
  input logic [3:0]         req_view,
  input logic [ID_W-1:0]    req_id,
  input logic               rsp_done,
  input logic               rsp_blocked,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic [NUM_REQ-1:0] wake_vec,
  input logic [CNT_W-1:0]   cnt,
  input logic [NUM_REQ-1:0] mask
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic pv_view;
  logic p_rd;
  logic v_wr;

  assign pv_view = (req_view == 4'd4) || (req_view == 4'd5);
  assign p_rd    = req_valid && !req_write && pv_view;
  assign v_wr    = req_valid &&  req_write && pv_view;

  // R2
  a_r2_acquire_dec: assert property (@(posedge clk) disable iff (!rst_ns)
    p_rd && cnt != '0 |=> rsp_done && cnt == $past(cnt) - 1'b1 &&
      rsp_rdata == {{(DATA_W-CNT_W){1'b0}}, $past(cnt)});

  // R3
  a_r3_block_records: assert property (@(posedge clk) disable iff (!rst_ns)
    p_rd && req_view == 4'd4 && cnt == '0 |=>
      rsp_blocked && !rsp_done && mask[$past(req_id)] && cnt == '0);

  // R4
  a_r4_try_zero_still: assert property (@(posedge clk) disable iff (!rst_ns)
    p_rd && req_view == 4'd5 && cnt == '0 |=>
      rsp_done && rsp_rdata == '0 && $stable(mask) && cnt == '0);

  // R5
  a_r5_release_inc: assert property (@(posedge clk) disable iff (!rst_ns)
    v_wr && cnt != CNT_TOP |=> cnt == $past(cnt) + 1'b1);

  a_r5_release_sat: assert property (@(posedge clk) disable iff (!rst_ns)
    v_wr && cnt == CNT_TOP |=> cnt == CNT_TOP);

  // R6
  a_r6_wake_clears: assert property (@(posedge clk) disable iff (!rst_ns)
    v_wr |=> mask == '0 && wake_vec == $past(mask));

  a_r6_wake_only_on_v: assert property (@(posedge clk) disable iff (!rst_ns)
    !v_wr |=> wake_vec == '0);

  // R11
  a_r11_single_resp: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0({rsp_done, rsp_blocked}));

  a_r11_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid |=> rsp_done || rsp_blocked);

  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_ns)
    !req_valid |=> !rsp_done && !rsp_blocked && rsp_rdata == '0);

endmodule

bind sema_cell sema_cell_chk #(
  .NUM_REQ (NUM_REQ),
  .CNT_W   (CNT_W),
  .DATA_W  (DATA_W),
  .ID_W    (ID_W)
) u_chk (
  .clk         (clk),
  .rst_ns      (rst_ns),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_view    (req_view),
  .req_id      (req_id),
  .rsp_done    (rsp_done),
  .rsp_blocked (rsp_blocked),
  .rsp_rdata   (rsp_rdata),
  .wake_vec    (wake_vec),
  .cnt         (cnt_q),
  .mask        (mask_q)
);

// File: tb/sema_cell_tb.sv
module sema_cell_tb_top;

  localparam int NUM_REQ = 8;
  localparam int CNT_W   = 16;
  localparam int DATA_W  = 32;
  localparam int ID_W    = 3;
  localparam int CNT_TOP = 65535;

  logic               clk;
  logic               rst_n;
  logic               req_valid;
  logic               req_write;
  logic [3:0]         req_view;
  logic [ID_W-1:0]    req_id;
  logic [DATA_W-1:0]  req_wdata;
  logic               rsp_done;
  logic               rsp_blocked;
  logic [DATA_W-1:0]  rsp_rdata;
  logic [NUM_REQ-1:0] wake_vec;

  sema_cell #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
    .clk, .rst_n, .req_valid, .req_write, .req_view, .req_id, .req_wdata,
    .rsp_done, .rsp_blocked, .rsp_rdata, .wake_vec
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 0;

  // reference model state
  int       m_cnt  = 0;
  bit [7:0] m_mask = '0;
  bit       m_t = 0, m_f = 0, m_e = 0;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  task automatic compare(string rq, bit e_done, bit e_blk, logic [31:0] e_rd, logic [7:0] e_wake);
    n_checks++;
    if (rsp_done !== e_done || rsp_blocked !== e_blk || rsp_rdata !== e_rd || wake_vec !== e_wake) begin
      n_fails++;
      $display("FAIL %s: actual done=%0b blk=%0b rd=%h wake=%h expected done=%0b blk=%0b rd=%h wake=%h",
               rq, rsp_done, rsp_blocked, rsp_rdata, wake_vec, e_done, e_blk, e_rd, e_wake);
    end
  endtask

  // One request (or idle) per call; entered and left at a falling edge.
  task automatic step(string rq, bit v, bit w, logic [3:0] vw, int id, logic [31:0] d);
    bit          e_done = 0, e_blk = 0;
    logic [31:0] e_rd   = '0;
    logic [7:0]  e_wake = '0;
    if (v) begin
      e_done = 1;
      case (vw)
        4'd0: if (!w) e_rd = m_cnt;
        4'd1: begin
          if (!w) e_rd = (32'(m_t) << 16) | (32'(m_f) << 1) | 32'(m_e);
          else begin m_t = d[16]; m_f = d[1]; m_e = d[0]; end
        end
        4'd2, 4'd3: e_rd = '0;
        4'd4, 4'd5: begin
          if (!w) begin
            if (m_cnt > 0) begin e_rd = m_cnt; m_cnt--; end
            else if (vw == 4'd4) begin e_done = 0; e_blk = 1; m_mask[id] = 1'b1; end
          end else begin
            e_wake = m_mask;
            m_mask = '0;
            if (m_cnt < CNT_TOP) m_cnt++;
          end
        end
        default: if (!w) e_rd = '1;
      endcase
    end
    req_valid = v; req_write = w; req_view = vw; req_id = ID_W'(id); req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    compare(rq, e_done, e_blk, e_rd, e_wake);
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_view = '0; req_id = '0; req_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    compare("R1", 0, 0, '0, '0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare("R1", 0, 0, '0, '0);
    step("R1", 1, 0, 4'd1, 0, '0);            // tag view reads 0, bit 17 clear
    step("R1", 1, 0, 4'd0, 0, '0);            // count 0

    // empty cell: try and blocking acquires
    step("R4", 1, 0, 4'd5, 2, '0);
    step("R3", 1, 0, 4'd4, 3, '0);
    step("R3", 1, 0, 4'd4, 5, '0);
    step("R4", 1, 0, 4'd5, 6, '0);            // must not add bit 6
    step("R7", 1, 1, 4'd2, 0, 32'hFFFF_FFFF);
    step("R7", 1, 1, 4'd3, 0, 32'h1234_5678);
    step("R7", 1, 0, 4'd2, 0, '0);
    step("R8", 1, 1, 4'd0, 0, 32'h0000_00AA);
    step("R8", 1, 0, 4'd0, 0, '0);
    step("R10", 1, 0, 4'd6, 0, '0);
    step("R10", 1, 0, 4'd15, 0, '0);
    step("R10", 1, 1, 4'd9, 0, 32'hFFFF_FFFF);
    step("R9", 1, 1, 4'd1, 0, 32'hFFFF_FFFF);
    step("R9", 1, 0, 4'd1, 0, '0);
    step("R9", 1, 1, 4'd1, 0, 32'h0001_0000);
    step("R9", 1, 0, 4'd1, 0, '0);
    step("R11", 0, 0, 4'd0, 0, '0);

    // release wakes both recorded waiters, data ignored
    step("R6", 1, 1, 4'd4, 7, 32'hDEAD_BEEF);
    step("R6", 1, 1, 4'd5, 1, 32'h0000_0100);
    step("R5", 1, 0, 4'd0, 0, '0);
    step("R2", 1, 0, 4'd4, 1, '0);
    step("R2", 1, 0, 4'd5, 1, '0);
    step("R3", 1, 0, 4'd4, 0, '0);
    step("R6", 1, 0, 4'd5, 4, '0);            // acquire never wakes
    step("R6", 1, 1, 4'd5, 4, '0);
    step("R11", 0, 0, 4'd0, 0, '0);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 15) step("R11", 0, 0, 4'd0, 0, '0);
      else step("R11", 1, $urandom_range(0, 1) == 1, 4'($urandom_range(0, 7)),
                $urandom_range(0, 7), $urandom);
    end

    // saturation
    while (m_cnt < CNT_TOP) step("R5", 1, 1, 4'd4, 0, '0);
    step("R5", 1, 1, 4'd5, 0, '0);
    step("R5", 1, 1, 4'd4, 0, '0);
    step("R5", 1, 0, 4'd0, 0, '0);
    step("R2", 1, 0, 4'd4, 0, '0);
    step("R8", 1, 0, 4'd0, 0, '0);
    report();
  end

endmodule